// File: doc/BRIEF.md
# Watchdog Timer with Rate Select

This block is a computer-operating-properly watchdog. It runs on the bus clock. A free-running prescaler divides the bus clock by 2^PRE_BITS, which is 2^15 by default. A scaled counter then counts prescaler ticks up to a factor of 1, 4, 16 or 64, chosen by a two-bit rate field. If software does not pulse the service input before the scaled counter reaches its end, the block raises a reset request for one bus cycle. The scaled counter then starts again from zero.

Two inputs are sampled only in the first cycle after reset. The watchdog enable decides whether the block can ever request a reset. The mode input selects normal operation or a special test/boot mode. In normal mode, the rate field takes a single write, and only during the first WIN bus cycles after reset. In special mode, the rate field can be rewritten at any time, and an inhibit flag blocks reset requests from startup. A clear strobe removes the inhibit.

The service strobe clears only the scaled counter. The prescaler keeps running. The timeout measured from a service is therefore never shorter than (F-1)·P+1 cycles and never longer than F·P cycles, where F is the scale factor and P = 2^PRE_BITS.

Top module: `wdt_cop`

## Requirements
- R1: After reset, `cop_rst_req` is 0 and `rate_cur` is 00.
- R2: With the watchdog running and no service, successive reset requests are exactly F·P cycles apart. The rate codes map to F as follows: 00 gives 1, 01 gives 4, 10 gives 16 and 11 gives 64.
- R3: Every reset request is high for exactly one cycle.
- R4: A service pulse clears only the scaled counter. The next request comes between (F-1)·P+1 and F·P cycles after the edge that samples the service. Regular servicing within that bound prevents any request. No request follows the cycle in which a service is sampled.
- R5: In normal mode, the first rate write within the first WIN (default 64) cycles after reset is accepted and shows on `rate_cur`.
- R6: In normal mode, a second rate write, or any write after the window has closed, leaves `rate_cur` unchanged.
- R7: In special mode, a rate write is accepted at any time.
- R8: `cfg_cop_en` is sampled only at reset. If it is low at reset, no request ever comes, even if it is raised later. If it is high at reset, lowering it later does not stop requests.
- R9: In special mode, requests are blocked from reset until `inh_clr` is pulsed, and then they resume. In normal mode, there is no inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cop_en | input | 1 | Watchdog enable, sampled at reset |
| special_mode | input | 1 | 1 = special test/boot mode, sampled at reset |
| inh_clr | input | 1 | Strobe that clears the special-mode inhibit |
| rate_wr | input | 1 | Rate field write strobe |
| rate_wdata | input | 2 | Rate code to write |
| service | input | 1 | Watchdog service strobe |
| rate_cur | output | 2 | Current rate code |
| cop_rst_req | output | 1 | One-cycle system reset request |

## Verification
A rate write sampled at a clock edge shows on `rate_cur` right after that edge. The bench therefore reads it one cycle after the write. The reset request is registered from the cycle in which the final prescaler tick is seen. For that reason, the bench measures periods and service-to-request delays as a count of rising edges, sampled 1 ns after each edge. It compares these counts with F·P, or with the [(F-1)·P+1, F·P] window, and does not predict an absolute cycle. The reset synchronizer adds two edges of uncertainty after `rst_n` rises, so write-window tests stay several cycles clear of the window boundary.

// File: rtl/wdt_cop_pkg.sv
package wdt_cop_pkg;
  typedef enum logic [1:0] {
    RATE_X1  = 2'b00,
    RATE_X4  = 2'b01,
    RATE_X16 = 2'b10,
    RATE_X64 = 2'b11
  } rate_e;

  localparam int unsigned MAX_RATE_CODE = 3;
  localparam int unsigned SC_BITS = 2 * MAX_RATE_CODE;

  function automatic logic [SC_BITS-1:0] rate_limit(input rate_e r);
    logic [SC_BITS:0] f;
    f = (SC_BITS+1)'(1) << (2 * r);
    return SC_BITS'(f - 1'b1);
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned PRE_BITS = 15
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [PRE_BITS-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = &cnt_q;

  // R2: the prescaler tick is a single-cycle pulse
  a_r2_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/wdt_rate_reg.sv
module wdt_rate_reg
  import wdt_cop_pkg::*;
#(
  parameter int unsigned WIN = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  special,
  input  logic  wr,
  input  rate_e wdata,
  output rate_e rate_q
);
  localparam int unsigned WBITS = $clog2(WIN + 1);
  localparam logic [WBITS-1:0] WIN_END = WBITS'(WIN);

  logic [WBITS-1:0] win_q, win_d;
  logic             done_q, done_d;
  rate_e            rate_d;
  logic             open, accept;

  always_comb begin
    open   = (win_q < WIN_END);
    accept = wr && (special || (open && !done_q));
    win_d  = open ? win_q + 1'b1 : win_q;
    done_d = done_q || (wr && !special && open);
    rate_d = accept ? wdata : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      done_q <= 1'b0;
      rate_q <= RATE_X1;
    end else begin
      win_q  <= win_d;
      done_q <= done_d;
      rate_q <= rate_d;
    end
  end

  // R6: once locked in normal mode the rate never changes
  a_r6_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!special && (done_q || !open)) |=> $stable(rate_q));
  // R7: special-mode writes always land
  a_r7_special_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (special && wr) |=> (rate_q == $past(wdata)));
endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler
  import wdt_cop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  service,
  input  rate_e rate,
  input  logic  active,
  output logic  req
);
  logic [SC_BITS-1:0] cnt_q, cnt_d;
  logic               req_d;
  logic               fire;

  always_comb begin
    fire  = tick && !service && (cnt_q >= rate_limit(rate));
    req_d = fire && active;
    if (service || fire) cnt_d = '0;
    else if (tick)       cnt_d = cnt_q + 1'b1;
    else                 cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      req   <= req_d;
    end
  end

  // R3: request lasts one cycle
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R4: a sampled service is never followed by a request
  a_r4_service_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> !req);
endmodule

// File: rtl/wdt_cop.sv
module wdt_cop
  import wdt_cop_pkg::*;
#(
  parameter int unsigned PRE_BITS = 15,
  parameter int unsigned WIN      = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_cop_en,
  input  logic       special_mode,
  input  logic       inh_clr,
  input  logic       rate_wr,
  input  logic [1:0] rate_wdata,
  input  logic       service,
  output logic [1:0] rate_cur,
  output logic       cop_rst_req
);
  logic [1:0] sync_q;
  logic       rst_i_n;
  logic       armed_q, en_q, mode_q, inh_q;
  logic       armed_d, en_d, mode_d, inh_d;
  logic       tick, active;
  rate_e      rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_i_n = sync_q[1];

  always_comb begin
    armed_d = 1'b1;
    en_d    = armed_q ? en_q   : cfg_cop_en;
    mode_d  = armed_q ? mode_q : special_mode;
    if (!armed_q)     inh_d = special_mode;
    else if (inh_clr) inh_d = 1'b0;
    else              inh_d = inh_q;
    active = en_q && !inh_q && armed_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      armed_q <= 1'b0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      inh_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      inh_q   <= inh_d;
    end
  end

  wdt_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .tick(tick)
  );

  wdt_rate_reg #(.WIN(WIN)) u_rate (
    .clk(clk), .rst_n(rst_i_n), .special(mode_q), .wr(rate_wr),
    .wdata(rate_e'(rate_wdata)), .rate_q(rate_q)
  );

  wdt_scaler u_scl (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .service(service),
    .rate(rate_q), .active(active), .req(cop_rst_req)
  );

  assign rate_cur = rate_q;

  // R8: a watchdog disabled at reset never requests
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_i_n)
    (armed_q && !en_q) |=> !cop_rst_req);
  // R9: no request while inhibited
  a_r9_inhibit: assert property (@(posedge clk) disable iff (!rst_i_n)
    inh_q |=> !cop_rst_req);
  // R8: sampled enable stays fixed until the next reset
  a_r8_en_frozen: assert property (@(posedge clk) disable iff (!rst_i_n)
    armed_q |=> $stable(en_q));
endmodule

// File: tb/sim_wdt_cop.sv
`timescale 1ns/1ps
module sim_wdt_cop;
  localparam int PB = 3;
  localparam int P  = 1 << PB;
  localparam int NV = 5;
  // {rate code, scale factor}
  localparam int VEC [NV][2] = '{'{0, 1}, '{1, 4}, '{2, 16}, '{3, 64}, '{1, 4}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_cop_en = 1'b0, special_mode = 1'b0, inh_clr = 1'b0;
  logic rate_wr = 1'b0, service = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic [1:0] rate_cur;
  logic cop_rst_req;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  wdt_cop #(.PRE_BITS(PB), .WIN(64)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cop_en(cfg_cop_en),
    .special_mode(special_mode), .inh_clr(inh_clr), .rate_wr(rate_wr),
    .rate_wdata(rate_wdata), .service(service), .rate_cur(rate_cur),
    .cop_rst_req(cop_rst_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode, input bit en);
    @(negedge clk);
    rst_n = 1'b0; special_mode = mode; cfg_cop_en = en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(input int lim, output bit found, output int n);
    found = 1'b0; n = 0;
    while (n < lim && !found) begin
      @(posedge clk); #1;
      n++;
      if (cop_rst_req) found = 1'b1;
    end
  endtask

  task automatic count_reqs(input int cyc, output int c);
    c = 0;
    for (int i = 0; i < cyc; i++) begin
      @(posedge clk); #1;
      if (cop_rst_req) c++;
    end
  endtask

  task automatic write_rate(input int code);
    @(negedge clk); rate_wr = 1'b1; rate_wdata = 2'(code);
    @(negedge clk); rate_wr = 1'b0;
  endtask

  task automatic pulse_service;
    @(negedge clk); service = 1'b1;
    @(negedge clk); service = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit f; int n, c;
    // R1 reset state, special mode with inhibit
    do_reset(1'b1, 1'b1);
    repeat (4) @(negedge clk);
    check(cop_rst_req == 1'b0, "R1 req", cop_rst_req, 0);
    check(rate_cur == 2'b00, "R1 rate", rate_cur, 0);
    count_reqs(100, c);
    check(c == 0, "R9 inhibited", c, 0);
    @(negedge clk); inh_clr = 1'b1; @(negedge clk); inh_clr = 1'b0;
    wait_req(3 * P, f, n);
    check(f, "R9 resumes", f, 1);

    // table walk: R7 writes, R2 periods, R3 width
    for (int v = 0; v < NV; v++) begin
      write_rate(VEC[v][0]);
      check(rate_cur == 2'(VEC[v][0]), "R7 rate", rate_cur, VEC[v][0]);
      wait_req(VEC[v][1] * P * 2 + 4, f, n);
      @(posedge clk); #1;
      check(!cop_rst_req, "R3 width", cop_rst_req, 0);
      wait_req(VEC[v][1] * P * 2, f, n);
      check(f && (n + 1 == VEC[v][1] * P), "R2 period", n + 1, VEC[v][1] * P);
    end

    // R4 service at each prescaler phase (rate 01: F=4)
    for (int k = 0; k < P; k++) begin
      wait_req(4 * P + 4, f, n);
      repeat (k) @(negedge clk);
      pulse_service();
      wait_req(8 * P, f, n);
      check(f && n >= 3 * P + 1 && n <= 4 * P, "R4 delay", n, 4 * P);
    end
    c = 0;
    for (int i = 0; i < 20; i++) begin
      pulse_service();
      for (int j = 0; j < 2 * P; j++) begin
        @(posedge clk); #1;
        if (cop_rst_req) c++;
      end
    end
    check(c == 0, "R4 serviced", c, 0);

    // R5/R6 normal mode, R9 no inhibit
    do_reset(1'b0, 1'b1);
    repeat (5) @(negedge clk);
    write_rate(2);
    check(rate_cur == 2'd2, "R5 first write", rate_cur, 2);
    write_rate(3);
    check(rate_cur == 2'd2, "R6 second write", rate_cur, 2);
    wait_req(16 * P * 2, f, n);
    check(f, "R9 normal no inhibit", f, 1);
    wait_req(16 * P * 2, f, n);
    check(f && n == 16 * P, "R2 normal period", n, 16 * P);
    do_reset(1'b0, 1'b1);
    repeat (80) @(negedge clk);
    write_rate(1);
    check(rate_cur == 2'd0, "R6 late write", rate_cur, 0);

    // R8 enable sampled at reset
    do_reset(1'b0, 1'b0);
    count_reqs(100, c);
    check(c == 0, "R8 disabled", c, 0);
    @(negedge clk); cfg_cop_en = 1'b1;
    count_reqs(100, c);
    check(c == 0, "R8 late enable", c, 0);
    do_reset(1'b0, 1'b1);
    repeat (6) @(negedge clk);
    cfg_cop_en = 1'b0;
    wait_req(4 * P, f, n);
    check(f, "R8 late disable", f, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule